// File: doc/BRIEF.md
# Multi-Mode Histogram Memory Engine

This block is a clocked processing engine wrapped around one 1024-word by 24-bit memory and one adder. A 3-bit function code picks how each clock edge uses the memory. It can count pixel values into bins or add a data word into the bin a pixel selects. It can turn a stored histogram into its running cumulative sum, or act as a look-up table. It can also act as a fixed 1024-cycle delay line, or as a delay line that subtracts the delayed word from the live input.

An active-low start input gates processing. It is sampled on every rising clock edge. An internal address counter restarts at zero whenever processing resumes.

A flash-clear input empties the whole memory in one step and forces the output register to zero at once. A host-ownership input parks the engine, so that another agent can use the memory without interference.

Top module: `hist_engine`

## Requirements
- R1: While `flash_clr_n` is low, `dout_o` is zero without waiting for a clock edge. After it is released, every memory word reads as zero until it is written again.
- R2: The mode register takes `func_i` only on a rising edge where `load_en` is high. Otherwise `func_i` has no effect. Codes: 000 bin count, 001 cumulative sum, 010 delay-subtract, 011 table, 100 bin add, 101 delay, 110 and 111 host-owned (engine parked).
- R3: An edge is active when `start_n` is low. On an inactive edge in bin count, cumulative, table or bin add mode, `dout_o` becomes the word at `pix_i`. In delay and delay-subtract modes, `dout_o` holds.
- R4: Bin count: each active edge adds one to the word at `pix_i`, and `dout_o` becomes the new count. Back-to-back hits on one address count every hit.
- R5: Bin add: each active edge adds `din_i` modulo 2^24 to the word at `pix_i`, and `dout_o` becomes the new sum.
- R6: The internal counter addresses word 0 on the first active edge after an inactive one. It then advances by one per active edge and wraps from 1023 to 0.
- R7: Table mode: on every edge `dout_o` becomes the word at `pix_i`, read before any write. Each active edge also writes `din_i` at the counter address.
- R8: Cumulative mode: each active edge replaces the word at the counter address with the running sum, modulo 2^24, of all words visited since the run began, this one included. `dout_o` shows that sum.
- R9: Delay mode: each active edge outputs the word at the counter address and then stores `din_i` there. A continuous run therefore outputs input from 1024 edges earlier.
- R10: Delay-subtract mode: it behaves as delay mode, except that `dout_o` is `din_i` minus the stored word, modulo 2^24.
- R11: While `host_own` is high, or a host-owned code is loaded, no memory word changes and `dout_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Active-low reset of mode register and counter control |
| flash_clr_n | input | 1 | Active-low asynchronous clear of memory and output path |
| load_en | input | 1 | Mode load strobe, sampled on the clock |
| func_i | input | 3 | Function code |
| start_n | input | 1 | Active-low processing enable, sampled on the clock |
| host_own | input | 1 | High parks the engine while another agent owns the memory |
| pix_i | input | 10 | Pixel value used as bin or table address |
| din_i | input | 24 | Data word for bin add, table, delay and subtract |
| dout_o | output | 24 | Registered result |

## Verification
A counter that misses its restart, or steps wrongly, shows up within one edge in table or delay output. It then persists as wrong words at pix-addressed reads. A stale or uncleared valid bit appears the first time its bin is read after a flash clear. A broken bypass of the read-modify-write loses counts on the very next back-to-back hit, and the cumulative sweep carries any single error into every later output of the run.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic [2:0] {
    MD_HIST   = 3'b000,
    MD_CUMUL  = 3'b001,
    MD_DSUB   = 3'b010,
    MD_TABLE  = 3'b011,
    MD_BINACC = 3'b100,
    MD_DELAY  = 3'b101,
    MD_HOST24 = 3'b110,
    MD_HOST16 = 3'b111
  } mode_e;

  typedef struct packed {
    logic run_en;   // engine may process this edge
    logic cnt_rd;   // active read address from counter
    logic cnt_wr;   // write address from counter
  } ctrl_t;
endpackage

// File: rtl/hist_mode_decode.sv
module hist_mode_decode
  import hist_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_en,
  input  logic [2:0] func_i,
  input  logic       host_own,
  output mode_e      mode_q,
  output ctrl_t      ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MD_HIST;
    else if (load_en) mode_q <= mode_e'(func_i);
  end

  always_comb begin
    ctrl.run_en = !host_own && (mode_q != MD_HOST24) && (mode_q != MD_HOST16);
    ctrl.cnt_rd = (mode_q == MD_CUMUL) || (mode_q == MD_DSUB) || (mode_q == MD_DELAY);
    ctrl.cnt_wr = ctrl.cnt_rd || (mode_q == MD_TABLE);
  end
endmodule

// File: rtl/hist_addr_gen.sv
module hist_addr_gen #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              start_n,
  output logic              active,
  output logic              first,
  output logic [ADDR_W-1:0] cnt_addr
);
  localparam logic [ADDR_W-1:0] STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic              idle_seen_q;
  logic [ADDR_W-1:0] cnt_q;

  assign active   = run_en && !start_n;
  assign first    = active && idle_seen_q;
  assign cnt_addr = first ? '0 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_seen_q <= 1'b1;
      cnt_q       <= '0;
    end else begin
      idle_seen_q <= !active;
      if (active) cnt_q <= cnt_addr + STEP;
    end
  end
endmodule

// File: rtl/hist_mem_array.sv
module hist_mem_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  vld;

  always_ff @(posedge clk) begin
    if (we) mem_q[wa] <= wd;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_vld
    logic bit_q;
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)                        bit_q <= 1'b0;
      else if (we && wa == ADDR_W'(g))   bit_q <= 1'b1;
    end
    assign vld[g] = bit_q;
  end

  assign rd = vld[ra] ? mem_q[ra] : '0;
endmodule

// File: rtl/hist_engine.sv
module hist_engine
  import hist_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flash_clr_n,
  input  logic              load_en,
  input  logic [2:0]        func_i,
  input  logic              start_n,
  input  logic              host_own,
  input  logic [ADDR_W-1:0] pix_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] a, b);
    return a + b;
  endfunction

  function automatic logic [DATA_W-1:0] wrap_sub(input logic [DATA_W-1:0] a, b);
    return a - b;
  endfunction

  mode_e             mode;
  ctrl_t             ctrl;
  logic              active, first;
  logic [ADDR_W-1:0] cnt_addr, rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data, sum;
  logic [DATA_W-1:0] dout_q, dout_nxt, acc_q, acc_nxt;
  logic              mem_we;
  logic              hist_act, idle_hold;

  hist_mode_decode u_dec (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .func_i(func_i),
    .host_own(host_own), .mode_q(mode), .ctrl(ctrl)
  );

  hist_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .clk(clk), .rst_n(rst_n), .run_en(ctrl.run_en), .start_n(start_n),
    .active(active), .first(first), .cnt_addr(cnt_addr)
  );

  assign rd_addr = (active && ctrl.cnt_rd) ? cnt_addr : pix_i;
  assign wr_addr = ctrl.cnt_wr ? cnt_addr : pix_i;

  hist_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .clr_n(flash_clr_n), .we(mem_we), .wa(wr_addr),
    .wd(wr_data), .ra(rd_addr), .rd(rd_data)
  );

  // named events for the checker
  assign hist_act  = active && (mode == MD_HIST);
  assign idle_hold = ctrl.run_en && start_n && ((mode == MD_DELAY) || (mode == MD_DSUB));

  always_comb begin
    mem_we   = 1'b0;
    wr_data  = din_i;
    dout_nxt = dout_q;
    acc_nxt  = acc_q;
    sum      = wrap_add(first ? '0 : acc_q, rd_data);
    if (ctrl.run_en) begin
      unique case (mode)
        MD_HIST: begin
          if (active) begin
            mem_we   = 1'b1;
            wr_data  = wrap_add(rd_data, ONE);
            dout_nxt = wr_data;
          end else dout_nxt = rd_data;
        end
        MD_BINACC: begin
          if (active) begin
            mem_we   = 1'b1;
            wr_data  = wrap_add(rd_data, din_i);
            dout_nxt = wr_data;
          end else dout_nxt = rd_data;
        end
        MD_CUMUL: begin
          if (active) begin
            mem_we   = 1'b1;
            wr_data  = sum;
            acc_nxt  = sum;
            dout_nxt = sum;
          end else dout_nxt = rd_data;
        end
        MD_TABLE: begin
          dout_nxt = rd_data;
          mem_we   = active;
        end
        MD_DELAY: begin
          if (active) begin
            mem_we   = 1'b1;
            dout_nxt = rd_data;
          end
        end
        MD_DSUB: begin
          if (active) begin
            mem_we   = 1'b1;
            dout_nxt = wrap_sub(din_i, rd_data);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge flash_clr_n) begin
    if (!flash_clr_n) begin
      dout_q <= '0;
      acc_q  <= '0;
    end else begin
      dout_q <= dout_nxt;
      acc_q  <= acc_nxt;
    end
  end

  assign dout_o = dout_q;
endmodule

// File: rtl/hist_engine_chk.sv
module hist_engine_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flash_clr_n,
  input logic [ADDR_W-1:0] pix_i,
  input logic [DATA_W-1:0] dout_o,
  input logic              run_en,
  input logic              active,
  input logic              first,
  input logic [ADDR_W-1:0] cnt_addr,
  input logic              hist_act,
  input logic              idle_hold
);
  // R1
  flash_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_clr_n |-> dout_o == '0);

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (!active || first || cnt_addr == ADDR_W'($past(cnt_addr) + 1'b1)));

  // R4
  hist_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_act && $past(hist_act) && pix_i == $past(pix_i) && flash_clr_n)
      |=> (!flash_clr_n || dout_o == DATA_W'($past(dout_o) + 1'b1)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_hold && flash_clr_n) |=> (!flash_clr_n || $stable(dout_o)));

  // R11
  host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && flash_clr_n) |=> (!flash_clr_n || $stable(dout_o)));
endmodule

bind hist_engine hist_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flash_clr_n(flash_clr_n), .pix_i(pix_i),
  .dout_o(dout_o), .run_en(ctrl.run_en), .active(active), .first(first),
  .cnt_addr(cnt_addr), .hist_act(hist_act), .idle_hold(idle_hold)
);

// File: tb/hist_engine_tb_top.sv
module hist_engine_tb_top;
  localparam int AW = 10;
  localparam int DW = 24;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n, flash_clr_n, load_en, start_n, host_own;
  logic [2:0]    func_i;
  logic [AW-1:0] pix_i;
  logic [DW-1:0] din_i, dout_o;

  int total = 0;
  int bad   = 0;
  logic [DW-1:0] ref_m [N];
  logic [DW-1:0] exp_v, acc, d;
  int unsigned seed_dummy;

  always #10 clk = ~clk;

  hist_engine dut_i (
    .clk(clk), .rst_n(rst_n), .flash_clr_n(flash_clr_n), .load_en(load_en),
    .func_i(func_i), .start_n(start_n), .host_own(host_own), .pix_i(pix_i),
    .din_i(din_i), .dout_o(dout_o)
  );

  function automatic logic [DW-1:0] tbl_val(input int i);
    return DW'(i * 40503 + 17);
  endfunction

  function automatic logic [DW-1:0] m_add(input logic [DW-1:0] a, b);
    logic [DW:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[DW-1:0];
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%06h exp=%06h", tag, act, expv);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [2:0] m);
    start_n = 1'b1; func_i = m; load_en = 1'b1;
    step;
    load_en = 1'b0;
    step;
  endtask

  task automatic zero_ref;
    for (int i = 0; i < N; i++) ref_m[i] = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'h5eed_1234);
    rst_n = 0; flash_clr_n = 0; load_en = 0; func_i = 3'b000;
    start_n = 1; host_own = 0; pix_i = '0; din_i = '0;
    zero_ref();
    step; step;
    chk("R1 reset output", dout_o, '0);
    rst_n = 1; flash_clr_n = 1;
    pix_i = 10'd5; step;
    chk("R1 reset memory", dout_o, '0);

    // R4 bin count, random small-range pixels, repeats likely
    start_n = 0;
    for (int k = 0; k < 300; k++) begin
      pix_i = (k % 50 == 7) ? 10'd1023 : AW'($urandom_range(0, 7));
      exp_v = m_add(ref_m[pix_i], 24'd1);
      ref_m[pix_i] = exp_v;
      step;
      chk("R4 count", dout_o, exp_v);
    end
    // R2: func change without load strobe is ignored
    func_i = 3'b101; pix_i = 10'd20;
    exp_v = m_add(ref_m[20], 24'd1); ref_m[20] = exp_v;
    step;
    chk("R2 no load", dout_o, exp_v);
    // R3 idle read
    start_n = 1;
    for (int p = 0; p < 8; p++) begin
      pix_i = AW'(p); step;
      chk("R3 idle read", dout_o, ref_m[p]);
    end

    // R5 bin add
    set_mode(3'b100);
    start_n = 0;
    for (int k = 0; k < 200; k++) begin
      pix_i = AW'($urandom_range(0, 15));
      din_i = DW'($urandom);
      exp_v = m_add(ref_m[pix_i], din_i);
      ref_m[pix_i] = exp_v;
      step;
      chk("R5 bin add", dout_o, exp_v);
    end

    // R7 table write over the whole array while reading random pixels
    set_mode(3'b011);
    start_n = 0;
    for (int i = 0; i < N; i++) begin
      pix_i = AW'($urandom);
      din_i = tbl_val(i);
      exp_v = ref_m[pix_i];
      ref_m[i] = din_i;
      step;
      chk("R7 table read", dout_o, exp_v);
    end
    // R6 restart at address 0
    start_n = 1; pix_i = 10'd3; step;
    chk("R7 idle table", dout_o, ref_m[3]);
    start_n = 0; din_i = 24'h5A5A5A;
    for (int i = 0; i < 3; i++) begin
      pix_i = 10'd100; exp_v = ref_m[100]; ref_m[i] = din_i;
      step;
      chk("R7 table read", dout_o, exp_v);
    end
    start_n = 1;
    for (int p = 0; p < 4; p++) begin
      pix_i = AW'(p); step;
      chk("R6 restart", dout_o, ref_m[p]);
    end

    // R8 cumulative sweep
    set_mode(3'b001);
    start_n = 0; acc = '0;
    for (int i = 0; i < N; i++) begin
      acc = m_add(acc, ref_m[i]);
      ref_m[i] = acc;
      step;
      chk("R8 cumulative", dout_o, acc);
    end
    start_n = 1;
    for (int k = 0; k < 6; k++) begin
      pix_i = AW'($urandom); step;
      chk("R8 stored sum", dout_o, ref_m[pix_i]);
    end

    // R1 flash clear, immediate and on memory
    flash_clr_n = 0; #2;
    chk("R1 flash output", dout_o, '0);
    #3 flash_clr_n = 1;
    zero_ref();
    pix_i = 10'd700; step;
    chk("R1 flash memory", dout_o, '0);

    // R9 delay, continuous run longer than the array (R6 wrap)
    set_mode(3'b101);
    start_n = 0; exp_v = '0;
    for (int i = 0; i < N + 20; i++) begin
      d = DW'($urandom);
      din_i = d;
      exp_v = ref_m[i % N];
      ref_m[i % N] = d;
      step;
      chk("R9 delay", dout_o, exp_v);
    end
    start_n = 1; pix_i = 10'd1; step;
    chk("R3 delay idle hold", dout_o, exp_v);

    // R10 delay-subtract
    set_mode(3'b010);
    chk("R3 dsub idle hold", dout_o, exp_v);
    start_n = 0;
    for (int i = 0; i < 300; i++) begin
      d = DW'($urandom);
      din_i = d;
      exp_v = d - ref_m[i];
      ref_m[i] = d;
      step;
      chk("R10 subtract", dout_o, exp_v);
    end

    // R11 host ownership and parked codes
    pix_i = 10'd9;
    set_mode(3'b000);
    chk("R3 idle read", dout_o, ref_m[9]);
    host_own = 1; start_n = 0; step;
    chk("R11 host hold", dout_o, ref_m[9]);
    host_own = 0; start_n = 1; step;
    chk("R11 no write", dout_o, ref_m[9]);
    set_mode(3'b110);
    pix_i = 10'd3; start_n = 0; step;
    chk("R11 parked hold", dout_o, ref_m[9]);
    set_mode(3'b000);
    chk("R11 parked no write", dout_o, ref_m[3]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule